// File: doc/BRIEF.md
# Indirect-Window Interrupt Controller Registers

This block is the software-visible register front end of a 24-line interrupt redirection controller. Software reaches every internal register through two offsets. It first writes a register index into a select register, then reads or writes the chosen 32-bit register through a data window. The index space holds an identity register, a read-only version register, an arbitration register that mirrors the identity, and one configuration word and one destination word for each interrupt line.

The stored table is presented in parallel to the interrupt core: all configuration words on one flat bus and all destination identifiers on another. The core returns two live status bits per line, delivery-pending and remote-acknowledge. These bits show through on configuration reads, and software writes cannot change them. Each configuration write produces a one-cycle pulse carrying the line number, so the core can re-evaluate that line.

Bus requests enter on a valid/ready channel, and each accepted request produces exactly one response on a second valid/ready channel. There is a single response slot. While a response is waiting and the consumer holds `rsp_ready` low, `req_ready` is low and no further request is taken. A response must stay valid and unchanged until it is consumed.

Top module: `idxwin_irq_regs`

## Requirements
- R1: After reset the select index is 0, the identity is 0, every configuration word is 0x0001_0000 (only the mask bit 16 set), every destination identifier is 0, no response is pending and `req_ready` is high.
- R2: A word write at offset 0x00 stores bits 7:0 of the data as the select index. A word read at offset 0x00 returns that index zero-extended.
- R3: Index 1 reads 0x0017_0011, with 0x11 in bits 7:0 and the last line number (23) in bits 23:16. Window writes to index 1 or index 2 change nothing.
- R4: Index 0 and index 2 both read the identity in bits 27:24, with all other bits zero. A window write to index 0 stores only bits 27:24 of the data.
- R5: Odd indices 0x11 to 0x3F select the destination word of line (index−0x10)>>1. A write keeps only bits 31:24, reads return them with the lower 24 bits zero, and the stored byte appears on `dst_ids` at line*8.
- R6: Even indices 0x10 to 0x3E select the configuration word of line (index−0x10)>>1. A write leaves bits 12, 14 and 31:17 unchanged and takes all other bits from the data. A read shows `core_deliv` in bit 12 and `core_rirr` in bit 14, and the stored word (bits 12 and 14 zero) appears on `cfg_words` at line*32.
- R7: A byte read (`req_word`=0) at offset 0x10+k, for k in 0..3, returns byte k of the selected register in bits 7:0, with byte 0 the least significant and the upper bits zero. Byte writes change no state.
- R8: A word access at any offset other than 0x00 and 0x10, and any window access with an index other than 0, 1, 2 or 0x10..0x3F, reads as zero and changes no state.
- R9: The cycle in which the response to a configuration write first becomes valid, `cfg_wr_pulse` is high for one cycle and `cfg_wr_line` gives the line. For any other request the pulse stays low.
- R10: Every accepted request yields one response in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data holds and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| core_deliv | input | 24 | Live delivery-pending bit per line |
| core_rirr | input | 24 | Live remote-acknowledge bit per line |
| cfg_words | output | 768 | Stored configuration word per line, line n at bits n*32 +: 32 |
| dst_ids | output | 192 | Destination identifier per line, line n at bits n*8 +: 8 |
| cfg_wr_pulse | output | 1 | One-cycle strobe after a configuration write |
| cfg_wr_line | output | 5 | Line number of the last configuration write |

## Verification
A scoreboard queues one expected response per request, and a monitor compares the responses in order. All-ones and mixed-pattern writes to configuration words show whether the protected bits leak into the stored word. Toggling the live core bits between reads separates stored bits from core-owned bits. Byte reads on a known pattern at each lane expose lane swaps. Writes to protected and unmapped indices, each followed by a read-back, distinguish "ignored" from "stored". A run with the consumer holding `rsp_ready` low tests whether the response slot holds its data and blocks new requests. Back-to-back configuration writes to different lines check that the strobe line number tracks each write.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  localparam int OFS_W = 8;
  localparam int IDX_W = 8;
  localparam int DATA_W = 32;

  localparam logic [OFS_W-1:0] OFS_SELECT = 8'h00;
  localparam logic [OFS_W-1:0] OFS_WINDOW = 8'h10;

  localparam logic [IDX_W-1:0] IDX_IDENT      = 8'h00;
  localparam logic [IDX_W-1:0] IDX_VERSION    = 8'h01;
  localparam logic [IDX_W-1:0] IDX_ARBIT      = 8'h02;
  localparam logic [IDX_W-1:0] IDX_TABLE_BASE = 8'h10;

  localparam int BIT_DELIV = 12;
  localparam int BIT_RIRR  = 14;
  localparam int BIT_MASK  = 16;
  localparam int ID_LSB    = 24;

  // software-writable bits of a configuration word: 16:15, 13, 11:0
  localparam logic [DATA_W-1:0] CFG_WR_MASK = 32'h0001_AFFF;
  localparam logic [DATA_W-1:0] CFG_RESET   = 32'h1 << BIT_MASK;
  localparam logic [7:0]        VERSION_CODE = 8'h11;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SELECT,
    TGT_IDENT,
    TGT_VERSION,
    TGT_ARBIT,
    TGT_CFG,
    TGT_DST
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [6:0] line;
    logic [1:0] lane;
    logic       byte_rd;
    logic       wr_ok;
  } dec_t;

endpackage

// File: rtl/idxwin_decode.sv
module idxwin_decode
  import idxwin_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic [OFS_W-1:0] addr,
  input  logic             word,
  input  logic             write,
  input  logic [IDX_W-1:0] sel,
  output dec_t             dec
);

  localparam logic [IDX_W:0] IDX_END = (IDX_W+1)'(16 + 2 * NUM_LINES);

  logic             in_window;
  logic             in_table;
  logic [IDX_W-1:0] rel_idx;
  tgt_e             win_tgt;

  always_comb begin
    in_window = (addr[OFS_W-1:2] == OFS_WINDOW[OFS_W-1:2]);
    rel_idx   = sel - IDX_TABLE_BASE;
    in_table  = (sel >= IDX_TABLE_BASE) && ({1'b0, sel} < IDX_END);

    if (sel == IDX_IDENT)        win_tgt = TGT_IDENT;
    else if (sel == IDX_VERSION) win_tgt = TGT_VERSION;
    else if (sel == IDX_ARBIT)   win_tgt = TGT_ARBIT;
    else if (in_table)           win_tgt = sel[0] ? TGT_DST : TGT_CFG;
    else                         win_tgt = TGT_NONE;
  end

  always_comb begin
    dec         = '0;
    dec.tgt     = TGT_NONE;
    dec.line    = rel_idx[IDX_W-1:1];
    dec.lane    = addr[1:0];
    if (word) begin
      if (addr == OFS_SELECT) begin
        dec.tgt   = TGT_SELECT;
        dec.wr_ok = write;
      end else if (addr == OFS_WINDOW) begin
        dec.tgt   = win_tgt;
        dec.wr_ok = write && ((win_tgt == TGT_IDENT) ||
                              (win_tgt == TGT_CFG)   ||
                              (win_tgt == TGT_DST));
      end
    end else if (!write && in_window) begin
      dec.tgt     = win_tgt;
      dec.byte_rd = 1'b1;
    end
  end

endmodule

// File: rtl/idxwin_entry_bank.sv
module idxwin_entry_bank
  import idxwin_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        dst_we,
  input  logic [LINE_W-1:0]           line,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_LINES*DATA_W-1:0] cfg_flat,
  output logic [NUM_LINES*8-1:0]      dst_flat
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [DATA_W-1:0] cfg_q;
    logic [7:0]        dst_q;
    logic              hit;

    assign hit = (line == LINE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= CFG_RESET;
        dst_q <= '0;
      end else begin
        if (cfg_we && hit)
          cfg_q <= (wdata & CFG_WR_MASK) | (cfg_q & ~CFG_WR_MASK);
        if (dst_we && hit)
          dst_q <= wdata[DATA_W-1 -: 8];
      end
    end

    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q;
    assign dst_flat[g*8 +: 8]           = dst_q;
  end

endmodule

// File: rtl/idxwin_readmux.sv
module idxwin_readmux
  import idxwin_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int ID_W      = 4
) (
  input  dec_t                        dec,
  input  logic [IDX_W-1:0]            sel,
  input  logic [ID_W-1:0]             ident,
  input  logic [NUM_LINES*DATA_W-1:0] cfg_flat,
  input  logic [NUM_LINES*8-1:0]      dst_flat,
  input  logic [NUM_LINES-1:0]        core_deliv,
  input  logic [NUM_LINES-1:0]        core_rirr,
  output logic [DATA_W-1:0]           rdata
);

  localparam logic [7:0] LAST_LINE = 8'(NUM_LINES - 1);

  logic [LINE_W-1:0] ln;
  logic [DATA_W-1:0] cfg_live;
  logic [DATA_W-1:0] ident_word;
  logic [DATA_W-1:0] word;

  always_comb begin
    ln = dec.line[LINE_W-1:0];
    if (32'(ln) >= NUM_LINES) ln = '0;

    cfg_live            = cfg_flat[ln*DATA_W +: DATA_W];
    cfg_live[BIT_DELIV] = core_deliv[ln];
    cfg_live[BIT_RIRR]  = core_rirr[ln];

    ident_word                  = '0;
    ident_word[ID_LSB +: ID_W]  = ident;

    case (dec.tgt)
      TGT_SELECT:  word = {{(DATA_W-IDX_W){1'b0}}, sel};
      TGT_IDENT:   word = ident_word;
      TGT_ARBIT:   word = ident_word;
      TGT_VERSION: word = {8'h00, LAST_LINE, 8'h00, VERSION_CODE};
      TGT_CFG:     word = cfg_live;
      TGT_DST:     word = {dst_flat[ln*8 +: 8], 24'h0};
      default:     word = '0;
    endcase

    if (dec.byte_rd) rdata = {24'h0, word[dec.lane*8 +: 8]};
    else             rdata = word;
  end

endmodule

// File: rtl/idxwin_irq_regs.sv
module idxwin_irq_regs
  import idxwin_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int ID_W      = 4,
  parameter int RESET_ID  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_word,
  input  logic [OFS_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [DATA_W-1:0]           rsp_rdata,
  input  logic [NUM_LINES-1:0]        core_deliv,
  input  logic [NUM_LINES-1:0]        core_rirr,
  output logic [NUM_LINES*DATA_W-1:0] cfg_words,
  output logic [NUM_LINES*8-1:0]      dst_ids,
  output logic                        cfg_wr_pulse,
  output logic [LINE_W-1:0]           cfg_wr_line
);

  logic [IDX_W-1:0]  sel_q;
  logic [ID_W-1:0]   ident_q;
  dec_t              dec;
  logic [DATA_W-1:0] rd_word;
  logic              accept;
  logic              do_wr;
  logic              cfg_we;
  logic              dst_we;
  logic [LINE_W-1:0] wr_line;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_wr     = accept && dec.wr_ok;
  assign cfg_we    = do_wr && (dec.tgt == TGT_CFG);
  assign dst_we    = do_wr && (dec.tgt == TGT_DST);
  assign wr_line   = dec.line[LINE_W-1:0];

  idxwin_decode #(.NUM_LINES(NUM_LINES)) u_dec (
    .addr  (req_addr),
    .word  (req_word),
    .write (req_write),
    .sel   (sel_q),
    .dec   (dec)
  );

  idxwin_entry_bank #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .dst_we   (dst_we),
    .line     (wr_line),
    .wdata    (req_wdata),
    .cfg_flat (cfg_words),
    .dst_flat (dst_ids)
  );

  idxwin_readmux #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .ID_W(ID_W)) u_rmux (
    .dec        (dec),
    .sel        (sel_q),
    .ident      (ident_q),
    .cfg_flat   (cfg_words),
    .dst_flat   (dst_ids),
    .core_deliv (core_deliv),
    .core_rirr  (core_rirr),
    .rdata      (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ident_q <= ID_W'(RESET_ID);
    end else if (do_wr) begin
      if (dec.tgt == TGT_SELECT) sel_q   <= req_wdata[IDX_W-1:0];
      if (dec.tgt == TGT_IDENT)  ident_q <= req_wdata[ID_LSB +: ID_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_wr_pulse <= 1'b0;
      cfg_wr_line  <= '0;
    end else begin
      cfg_wr_pulse <= cfg_we;
      if (cfg_we) cfg_wr_line <= wr_line;
    end
  end

endmodule

// File: rtl/idxwin_irq_regs_chk.sv
module idxwin_irq_regs_chk #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic                      req_word,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [31:0]               rsp_rdata,
  input logic [NUM_LINES*32-1:0]   cfg_words,
  input logic [NUM_LINES*8-1:0]    dst_ids,
  input logic                      cfg_wr_pulse,
  input logic [LINE_W-1:0]         cfg_wr_line
);

  assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_block_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_byte_wr_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !req_word) |=>
      ($stable(cfg_words) && $stable(dst_ids)));

  assert_read_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=>
      ($stable(cfg_words) && $stable(dst_ids)));

  assert_pulse_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_pulse |-> (rsp_valid && (32'(cfg_wr_line) < NUM_LINES)));

endmodule

bind idxwin_irq_regs idxwin_irq_regs_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_word     (req_word),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .cfg_words    (cfg_words),
  .dst_ids      (dst_ids),
  .cfg_wr_pulse (cfg_wr_pulse),
  .cfg_wr_line  (cfg_wr_line)
);

// File: tb/sim_idxwin_irq_regs.sv
`timescale 1ns/1ps
module sim_idxwin_irq_regs;

  localparam int N  = 24;
  localparam int LW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic            req_word = 1'b1;
  logic [7:0]      req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [31:0]     rsp_rdata;
  logic [N-1:0]    core_deliv = '0;
  logic [N-1:0]    core_rirr = '0;
  logic [N*32-1:0] cfg_words;
  logic [N*8-1:0]  dst_ids;
  logic            cfg_wr_pulse;
  logic [LW-1:0]   cfg_wr_line;

  always #2 clk = ~clk;

  idxwin_irq_regs #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .core_deliv(core_deliv), .core_rirr(core_rirr),
    .cfg_words(cfg_words), .dst_ids(dst_ids),
    .cfg_wr_pulse(cfg_wr_pulse), .cfg_wr_line(cfg_wr_line)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    pv = 1'b0;
  bit    pr = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          pulse_q[$];
  int          line_q[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(bit wr, bit word, logic [7:0] addr, logic [31:0] wd,
                      logic [31:0] exp, string tag, bit pulse = 1'b0, int line = 0);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    pulse_q.push_back(pulse);
    line_q.push_back(line);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = word;
    req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic wsel(logic [31:0] idx);
    send(1'b1, 1'b1, 8'h00, idx, 32'h0, "R2 select write");
  endtask

  task automatic rwin(logic [31:0] exp, string tag);
    send(1'b0, 1'b1, 8'h10, 32'h0, exp, tag);
  endtask

  task automatic wwin(logic [31:0] d, string tag, bit pulse = 1'b0, int line = 0);
    send(1'b1, 1'b1, 8'h10, d, 32'h0, tag, pulse, line);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected responses in order
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && !(pv && !pr)) begin
        if (pulse_q.size() != 0) begin
          if (pulse_q[0])
            check(cfg_wr_pulse && (int'(cfg_wr_line) == line_q[0]),
                  {"R9 strobe ", tag_q[0]}, {cfg_wr_pulse, 26'h0, cfg_wr_line},
                  {1'b1, 26'h0, 5'(line_q[0])});
          else
            check(!cfg_wr_pulse, {"R9 no strobe ", tag_q[0]}, 32'(cfg_wr_pulse), 32'h0);
        end
      end else if (cfg_wr_pulse) begin
        check(1'b0, "R9 stray strobe", 32'h1, 32'h0);
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
        end else begin
          check(rsp_rdata == exp_q[0], tag_q[0], rsp_rdata, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          void'(pulse_q.pop_front());
          void'(line_q.pop_front());
        end
      end
      pv = rsp_valid;
      pr = rsp_ready;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check(!rsp_valid && req_ready, "R1 handshake idle", {rsp_valid, req_ready}, 32'h1);
    for (int i = 0; i < N; i++) begin
      check(cfg_words[i*32 +: 32] == 32'h0001_0000, "R1 cfg reset", cfg_words[i*32 +: 32], 32'h0001_0000);
      check(dst_ids[i*8 +: 8] == 8'h00, "R1 dst reset", 32'(dst_ids[i*8 +: 8]), 32'h0);
    end
    send(1'b0, 1'b1, 8'h00, 0, 32'h0, "R1 select reset");
    rwin(32'h0, "R1 identity reset");
    wsel(32'h10);
    rwin(32'h0001_0000, "R1 cfg line0 reset via window");

    // R2 select stores 8 bits
    wsel(32'hABCD_EF17);
    send(1'b0, 1'b1, 8'h00, 0, 32'h0000_0017, "R2 select readback");

    // R3 version and protected indices
    wsel(32'h1);
    rwin(32'h0017_0011, "R3 version");
    wwin(32'hFFFF_FFFF, "R3 version write");
    rwin(32'h0017_0011, "R3 version after write");
    wsel(32'h2);
    wwin(32'hFFFF_FFFF, "R3 arbit write");
    rwin(32'h0, "R3 arbit unchanged");

    // R4 identity
    wsel(32'h0);
    wwin(32'hA5B6_C7D8, "R4 identity write");
    rwin(32'h0500_0000, "R4 identity readback");
    wsel(32'h2);
    rwin(32'h0500_0000, "R4 arbit mirrors identity");

    // R5 destination word
    wsel(32'h17);
    wwin(32'h1234_5678, "R5 dst write");
    rwin(32'h1200_0000, "R5 dst readback");
    wsel(32'h3F);
    wwin(32'hFFFF_FFFF, "R5 dst last line write");
    rwin(32'hFF00_0000, "R5 dst last line readback");
    drain();
    check(dst_ids[3*8 +: 8] == 8'h12, "R5 dst port line3", 32'(dst_ids[3*8 +: 8]), 32'h12);
    check(dst_ids[23*8 +: 8] == 8'hFF, "R5 dst port line23", 32'(dst_ids[23*8 +: 8]), 32'hFF);

    // R6 configuration word with protected and live bits
    wsel(32'h1A);
    wwin(32'hFFFF_FFFF, "R6 cfg all-ones write", 1'b1, 5);
    rwin(32'h0001_AFFF, "R6 cfg protected bits");
    drain();
    check(cfg_words[5*32 +: 32] == 32'h0001_AFFF, "R6 cfg port line5", cfg_words[5*32 +: 32], 32'h0001_AFFF);
    core_deliv[5] = 1'b1; core_rirr[5] = 1'b1;
    rwin(32'h0001_FFFF, "R6 cfg live bits set");
    wwin(32'h0, "R6 cfg zero write", 1'b1, 5);
    rwin(32'h0000_5000, "R6 cfg only live bits");
    drain();
    check(cfg_words[5*32 +: 32] == 32'h0, "R6 cfg port cleared", cfg_words[5*32 +: 32], 32'h0);
    core_deliv[5] = 1'b0; core_rirr[5] = 1'b0;
    rwin(32'h0, "R6 cfg live bits clear");
    wsel(32'h3E);
    wwin(32'h0000_80AB, "R6 cfg last line write", 1'b1, 23);
    rwin(32'h0000_80AB, "R6 cfg last line readback");

    // R9 back-to-back configuration writes on two lines
    wsel(32'h12);
    send(1'b1, 1'b1, 8'h10, 32'h20, 32'h0, "R9 cfg line1 write", 1'b1, 1);
    wsel(32'h14);
    send(1'b1, 1'b1, 8'h10, 32'h30, 32'h0, "R9 cfg line2 write", 1'b1, 2);
    send(1'b1, 1'b1, 8'h10, 32'h31, 32'h0, "R9 cfg line2 rewrite", 1'b1, 2);
    rwin(32'h31, "R9 cfg line2 readback");

    // R7 byte lanes
    wsel(32'h17);
    send(1'b0, 1'b0, 8'h10, 0, 32'h00, "R7 dst byte0");
    send(1'b0, 1'b0, 8'h13, 0, 32'h12, "R7 dst byte3");
    wsel(32'h1);
    send(1'b0, 1'b0, 8'h10, 0, 32'h11, "R7 version byte0");
    send(1'b0, 1'b0, 8'h11, 0, 32'h00, "R7 version byte1");
    send(1'b0, 1'b0, 8'h12, 0, 32'h17, "R7 version byte2");
    send(1'b0, 1'b0, 8'h13, 0, 32'h00, "R7 version byte3");
    wsel(32'h17);
    send(1'b1, 1'b0, 8'h13, 32'hFFFF_FFFF, 32'h0, "R7 byte write");
    rwin(32'h1200_0000, "R7 byte write ignored");

    // R8 unmapped offsets and indices
    wsel(32'h40);
    wwin(32'hFFFF_FFFF, "R8 out-of-range write");
    rwin(32'h0, "R8 out-of-range read");
    wsel(32'h3);
    rwin(32'h0, "R8 gap index read");
    wsel(32'h5);
    send(1'b0, 1'b1, 8'h04, 0, 32'h0, "R8 unmapped word read");
    send(1'b1, 1'b1, 8'h08, 32'h3, 32'h0, "R8 unmapped word write");
    send(1'b0, 1'b1, 8'h11, 0, 32'h0, "R8 misaligned word read");
    send(1'b0, 1'b0, 8'h00, 0, 32'h0, "R8 byte read of select");
    send(1'b0, 1'b1, 8'h00, 0, 32'h5, "R8 select unchanged");
    drain();
    for (int i = 0; i < N; i++) begin
      if (i != 1 && i != 2 && i != 5 && i != 23)
        check(cfg_words[i*32 +: 32] == 32'h0001_0000, "R8 other cfg untouched",
              cfg_words[i*32 +: 32], 32'h0001_0000);
    end

    // R10 back-pressure
    wsel(32'h1);
    drain();
    rsp_ready = 1'b0;
    rwin(32'h0017_0011, "R10 stalled read");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_rdata == 32'h0017_0011, "R10 stall hold",
            rsp_rdata, 32'h0017_0011);
    end
    rsp_ready = 1'b1;
    drain();
    check(!rsp_valid && req_ready, "R10 slot released", {rsp_valid, req_ready}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule